// File: doc/BRIEF.md
# Flash Line Buffer Prefetch Controller

This block sits between one read-only bus master and a slow flash array. Reads that hit one of a few line buffers are answered in the cycle after acceptance. Reads that miss fetch one whole line from flash, and that fetch takes a programmable number of wait states plus one cycle. The master tags each request as an instruction fetch or a data read. That tag decides which buffers a new line may replace and which prefetch enable applies.

One configuration word controls the block. It sets the global buffer enable, separate sequential-prefetch enables for instruction and data reads, a trigger policy for prefetching (never, after a miss only, or after a hit or a miss), and the buffer partition (all buffers pooled, or every buffer but the last for instructions with the last reserved for data). It also sets the flash wait-state count. A new configuration is held back until no flash fetch is running. When it applies, all buffers are invalidated. In this project the flash array is a behavioural model whose contents are a fixed function of the word address.

Top module: `flash_lbuf_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. Buffering and prefetch are off and the wait-state count is 0.
- R2: Configuration word fields: bit 0 enables buffering, bit 1 enables instruction prefetch, bit 2 enables data prefetch, bits 5:4 set the prefetch trigger, bits 9:8 set the partition, and bits 19:16 set the wait-state count W.
- R3: With buffering off, every read goes to flash, so two reads of the same address both take W+1 cycles. No buffer ever becomes valid while buffering is off.
- R4: A buffer hit raises `rsp_valid` in the cycle after the accepting edge, with no added wait state. Byte-address bits 3:2 select one 32-bit word of the 128-bit line. The flash word at word index w = address>>2 is {w[15:0] xor 16'hA5C3, w[15:0]}.
- R5: A miss with flash idle raises `rsp_valid` W+1 clock edges after the accepting edge.
- R6: Partition value 3 lets instruction lines replace only buffers 0 to NB-2 and data lines only buffer NB-1. Values 0, 1 and 2 pool all buffers. Any buffer may supply a hit.
- R7: A new line replaces the least recently used buffer of the partition that matches its access type. Hits and fills both count as uses.
- R8: The line after an accessed line is prefetched only when the prefetch enable for that access's type is set. The prefetched line is placed using that type's partition.
- R9: Trigger value 0 never prefetches. Value 1 prefetches only after a miss. Values 2 and 3 prefetch after a hit or a miss.
- R10: Only one flash fetch runs at a time. A demand miss is issued before a queued prefetch that has not started.
- R11: A demand read of the line currently being prefetched waits for that fetch and does not start a second one.
- R12: A configuration write takes effect only when no flash fetch is running, and it invalidates every buffer. `req_ready` is 0 while the write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request accepted on an edge where both valid and ready are 1 |
| req_addr | input | AW | Byte address of the read |
| req_instr | input | 1 | 1 for an instruction fetch, 0 for a data read |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_data | output | 32 | Read data word |

## Verification
The bench builds the block with its defaults: a 16-bit address, four buffers and 128-bit lines. With these values the three-plus-one split is small enough that a few reads exhaust the data buffer and still leave the instruction lines resident, and the pooled mode can be driven through a full replacement cycle. The bench sets wait-state counts 0, 1, 2, 3 and 5 through the configuration word. A count of 5 leaves enough cycles for a demand read to land during a running prefetch, to queue behind one, or to arrive while a configuration write is held back.

// File: rtl/flb_pkg.sv
package flb_pkg;

  localparam int FLB_RWS_W = 4;

  typedef struct packed {
    logic [FLB_RWS_W-1:0] rwsc;
    logic [1:0]           part;
    logic [1:0]           lim;
    logic                 dpf;
    logic                 ipf;
    logic                 buf_en;
  } flb_cfg_t;

  typedef enum logic {S_IDLE, S_WAIT} flb_state_t;

endpackage

// File: rtl/flb_flash_model.sv
module flb_flash_model #(
  parameter int LA     = 12,
  parameter int LINE_W = 128,
  parameter int RW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LA-1:0]     start_line,
  input  logic [RW-1:0]     rwsc,
  output logic              busy,
  output logic              done,
  output logic [LA-1:0]     cur_line,
  output logic [LINE_W-1:0] line_data
);
  localparam int WPL   = LINE_W / 32;
  localparam int WSL_W = $clog2(WPL);

  logic [RW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      cur_line <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      cnt      <= rwsc;
      cur_line <= start_line;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  // Array contents: a fixed function of the word index
  always_comb begin
    for (int k = 0; k < WPL; k++) begin
      logic [31:0] wi;
      wi = (32'(cur_line) << WSL_W) | 32'(k);
      line_data[k*32 +: 32] = {wi[15:0] ^ 16'hA5C3, wi[15:0]};
    end
  end

endmodule

// File: rtl/flb_lru.sv
module flb_lru #(
  parameter int NB = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  touch_a,
  input  logic [$clog2(NB)-1:0] idx_a,
  input  logic                  touch_b,
  input  logic [$clog2(NB)-1:0] idx_b,
  input  logic [NB-1:0]         vmask,
  output logic [$clog2(NB)-1:0] victim
);
  localparam int IDX_W = $clog2(NB);
  localparam int AGE_W = IDX_W;

  typedef logic [NB-1:0][AGE_W-1:0] ages_t;

  ages_t age_q, age_a, age_b;

  function automatic ages_t touch(input ages_t a, input logic [IDX_W-1:0] idx);
    ages_t r;
    for (int j = 0; j < NB; j++) begin
      if (IDX_W'(j) == idx)   r[j] = '0;
      else if (a[j] < a[idx]) r[j] = a[j] + 1'b1;
      else                    r[j] = a[j];
    end
    return r;
  endfunction

  always_comb begin
    age_a = touch_a ? touch(age_q, idx_a) : age_q;
    age_b = touch_b ? touch(age_a, idx_b) : age_a;
  end

  always_comb begin
    logic             found;
    logic [AGE_W-1:0] best;
    found  = 1'b0;
    best   = '0;
    victim = '0;
    for (int b = 0; b < NB; b++) begin
      if (vmask[b] && (!found || age_q[b] > best)) begin
        found  = 1'b1;
        best   = age_q[b];
        victim = IDX_W'(b);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NB; b++) age_q[b] <= AGE_W'(b);
    end else begin
      age_q <= age_b;
    end
  end

endmodule

// File: rtl/flash_lbuf_ctrl.sv
module flash_lbuf_ctrl #(
  parameter int AW     = 16,
  parameter int NB     = 4,
  parameter int LINE_W = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [31:0]   cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_instr,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data
);
  import flb_pkg::*;

  localparam int WPL   = LINE_W / 32;
  localparam int WSL_W = $clog2(WPL);
  localparam int OFF_W = WSL_W + 2;
  localparam int LA    = AW - OFF_W;
  localparam int IDX_W = $clog2(NB);

  // configuration
  flb_cfg_t cfg_q, cfg_new, cfg_dec;
  logic     cfg_pend, cfg_apply;
  logic     bufs_on, split_mode;
  logic     unused_bits;

  assign cfg_dec = '{rwsc: cfg_wdata[16 +: FLB_RWS_W], part: cfg_wdata[9:8],
                     lim: cfg_wdata[5:4], dpf: cfg_wdata[2], ipf: cfg_wdata[1],
                     buf_en: cfg_wdata[0]};
  assign unused_bits = ^{cfg_wdata[31:16+FLB_RWS_W], cfg_wdata[15:10],
                         cfg_wdata[7:6], cfg_wdata[3], req_addr[1:0]};
  assign bufs_on    = cfg_q.buf_en;
  assign split_mode = (cfg_q.part == 2'd3);

  // line buffers
  logic [LINE_W-1:0] buf_data [NB];
  logic [LA-1:0]     buf_tag  [NB];
  logic [NB-1:0]     buf_valid;

  // request decode
  logic [LA-1:0]    req_line, nxt_line;
  logic [WSL_W-1:0] req_word;
  assign req_line = req_addr[AW-1:OFF_W];
  assign req_word = req_addr[OFF_W-1:2];
  assign nxt_line = req_line + LA'(1);

  // control state
  flb_state_t       state;
  logic [LA-1:0]    d_line;
  logic [WSL_W-1:0] d_word;
  logic             d_instr;
  logic             pf_pend, pf_instr;
  logic [LA-1:0]    pf_line;
  logic             fl_instr;

  // flash model interface
  logic              fl_start, fl_busy, fl_done;
  logic [LA-1:0]     fl_sline, fl_cur;
  logic [LINE_W-1:0] fl_data;

  // lookup
  logic [NB-1:0]    hit_vec, nxt_vec, pf_vec, mask_i, mask_d;
  logic [IDX_W-1:0] hit_idx, victim;
  logic             hit_any;

  for (genvar b = 0; b < NB; b++) begin : g_lookup
    assign hit_vec[b] = bufs_on && buf_valid[b] && (buf_tag[b] == req_line);
    assign nxt_vec[b] = buf_valid[b] && (buf_tag[b] == nxt_line);
    assign pf_vec[b]  = buf_valid[b] && (buf_tag[b] == pf_line);
    assign mask_i[b]  = !split_mode || (b < NB - 1);
    assign mask_d[b]  = !split_mode || (b == NB - 1);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (hit_vec[b]) hit_idx = IDX_W'(b);
    end
  end

  // datapath decisions
  logic acc, fl_free, in_flight_req, fill_match_req, idle_miss, wait_done;
  logic dem_start, dem_instr, pf_type_en, pf_go, pf_try, pf_drop, pf_start, fill_en;
  logic [LA-1:0] dem_line;

  assign req_ready      = (state == S_IDLE) && !cfg_pend;
  assign acc            = req_ready && req_valid;
  assign fl_free        = !fl_busy || fl_done;
  assign in_flight_req  = fl_busy && (fl_cur == req_line);
  assign fill_match_req = fl_done && (fl_cur == req_line);
  assign idle_miss      = acc && !hit_any && !in_flight_req;
  assign wait_done      = (state == S_WAIT) && fl_done && (fl_cur == d_line);

  assign dem_start = (idle_miss && fl_free) ||
                     ((state == S_WAIT) && fl_free && !wait_done);
  assign dem_line  = (state == S_WAIT) ? d_line : req_line;
  assign dem_instr = (state == S_WAIT) ? d_instr : req_instr;

  assign pf_type_en = req_instr ? cfg_q.ipf : cfg_q.dpf;
  assign pf_go = acc && bufs_on && pf_type_en &&
                 (cfg_q.lim[1] || ((cfg_q.lim == 2'd1) && !hit_any)) &&
                 !(|nxt_vec) && !(fl_busy && (fl_cur == nxt_line));
  assign pf_try   = (state == S_IDLE) && !cfg_pend && pf_pend && fl_free && !dem_start;
  assign pf_drop  = (|pf_vec) || (fl_done && (fl_cur == pf_line));
  assign pf_start = pf_try && !pf_drop;

  assign fl_start  = dem_start || pf_start;
  assign fl_sline  = dem_start ? dem_line : pf_line;
  assign fill_en   = fl_done && bufs_on;
  assign cfg_apply = cfg_pend && (state == S_IDLE) && !fl_busy;

  flb_flash_model #(.LA(LA), .LINE_W(LINE_W), .RW(FLB_RWS_W)) flash_i (
    .clk       (clk),
    .rst       (rst),
    .start     (fl_start),
    .start_line(fl_sline),
    .rwsc      (cfg_q.rwsc),
    .busy      (fl_busy),
    .done      (fl_done),
    .cur_line  (fl_cur),
    .line_data (fl_data)
  );

  flb_lru #(.NB(NB)) lru_i (
    .clk    (clk),
    .rst    (rst),
    .touch_a(fill_en),
    .idx_a  (victim),
    .touch_b(acc && hit_any),
    .idx_b  (hit_idx),
    .vmask  (fl_instr ? mask_i : mask_d),
    .victim (victim)
  );

  // buffer storage, no reset so it maps to plain memory
  always_ff @(posedge clk) begin
    if (fill_en) begin
      buf_data[victim] <= fl_data;
      buf_tag[victim]  <= fl_cur;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      buf_valid <= '0;
      cfg_q     <= '0;
      cfg_new   <= '0;
      cfg_pend  <= 1'b0;
      pf_pend   <= 1'b0;
      pf_line   <= '0;
      pf_instr  <= 1'b0;
      fl_instr  <= 1'b0;
      d_line    <= '0;
      d_word    <= '0;
      d_instr   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;

      if (acc) begin
        if (hit_any) begin
          rsp_valid <= 1'b1;
          rsp_data  <= buf_data[hit_idx][req_word*32 +: 32];
        end else if (fill_match_req) begin
          rsp_valid <= 1'b1;
          rsp_data  <= fl_data[req_word*32 +: 32];
        end else begin
          state   <= S_WAIT;
          d_line  <= req_line;
          d_word  <= req_word;
          d_instr <= req_instr;
        end
      end

      if (wait_done) begin
        rsp_valid <= 1'b1;
        rsp_data  <= fl_data[d_word*32 +: 32];
        state     <= S_IDLE;
      end

      if (fl_start) fl_instr <= dem_start ? dem_instr : pf_instr;

      if (pf_go) begin
        pf_pend  <= 1'b1;
        pf_line  <= nxt_line;
        pf_instr <= req_instr;
      end else if (pf_try) begin
        pf_pend <= 1'b0;
      end

      if (fill_en) buf_valid[victim] <= 1'b1;

      if (cfg_apply) begin
        cfg_q     <= cfg_new;
        buf_valid <= '0;
        pf_pend   <= 1'b0;
        cfg_pend  <= 1'b0;
      end
      if (cfg_we) begin
        cfg_new  <= cfg_dec;
        cfg_pend <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flb_chk.sv
module flb_chk #(
  parameter int NB = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  acc,
  input logic                  hit_any,
  input logic                  rsp_valid,
  input logic                  fl_start,
  input logic                  fl_busy,
  input logic                  fl_done,
  input logic                  cfg_apply,
  input logic                  cfg_pend,
  input logic                  req_ready,
  input logic                  bufs_on,
  input logic [NB-1:0]         buf_valid,
  input logic                  fill_en,
  input logic                  split_mode,
  input logic                  fl_instr,
  input logic [$clog2(NB)-1:0] victim
);
  localparam int IDX_W = $clog2(NB);

  a_r4_hit_responds: assert property (@(posedge clk) disable iff (rst)
    acc && hit_any |=> rsp_valid);

  a_r10_one_fetch: assert property (@(posedge clk) disable iff (rst)
    fl_start |-> (!fl_busy || fl_done));

  a_r12_apply_idle: assert property (@(posedge clk) disable iff (rst)
    cfg_apply |-> !fl_busy);

  a_r12_ready_held: assert property (@(posedge clk) disable iff (rst)
    cfg_pend |-> !req_ready);

  a_r3_off_empty: assert property (@(posedge clk) disable iff (rst)
    !bufs_on |-> (buf_valid == '0));

  a_r6_data_slot: assert property (@(posedge clk) disable iff (rst)
    fill_en && split_mode && !fl_instr |-> (victim == IDX_W'(NB - 1)));

  a_r6_instr_slot: assert property (@(posedge clk) disable iff (rst)
    fill_en && split_mode && fl_instr |-> (victim != IDX_W'(NB - 1)));

endmodule

bind flash_lbuf_ctrl flb_chk #(.NB(NB)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .acc       (acc),
  .hit_any   (hit_any),
  .rsp_valid (rsp_valid),
  .fl_start  (fl_start),
  .fl_busy   (fl_busy),
  .fl_done   (fl_done),
  .cfg_apply (cfg_apply),
  .cfg_pend  (cfg_pend),
  .req_ready (req_ready),
  .bufs_on   (bufs_on),
  .buf_valid (buf_valid),
  .fill_en   (fill_en),
  .split_mode(split_mode),
  .fl_instr  (fl_instr),
  .victim    (victim)
);

// File: tb/flash_lbuf_ctrl_tb_top.sv
module flash_lbuf_ctrl_tb_top;
  localparam int AW = 16;
  localparam int NV = 11;

  // split mode table: W = 3, instruction prefetch, trigger on hit or miss
  localparam logic [15:0] V_ADDR  [NV] = '{16'h000, 16'h004, 16'h010, 16'h020, 16'h030,
                                           16'h100, 16'h104, 16'h200, 16'h040, 16'h100,
                                           16'h000};
  localparam bit          V_INSTR [NV] = '{1, 1, 1, 1, 1, 0, 0, 0, 1, 0, 1};
  localparam int          V_LAT   [NV] = '{4, 0, 0, 0, 0, 4, 0, 4, 0, 4, 4};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_instr = 1'b0;
  logic          rsp_valid;
  logic [31:0]   rsp_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flash_lbuf_ctrl #(.AW(AW), .NB(4), .LINE_W(128)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_instr(req_instr), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [15:0] a);
    logic [15:0] w;
    w = {2'b00, a[15:2]};
    return {w ^ 16'hA5C3, w};
  endfunction

  task automatic cfg_write(input logic [31:0] w);
    @(negedge clk);
    cfg_wdata = w;
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  // called at a negedge; returns edges from acceptance to visible response
  task automatic rd(input logic [15:0] a, input bit ins, input int gap,
                    output int lat, output logic [31:0] d);
    repeat (gap) @(negedge clk);
    req_addr  = a;
    req_instr = ins;
    req_valid = 1'b1;
    while (!req_ready) begin
      @(posedge clk);
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    d = rsp_data;
  endtask

  task automatic rd_chk(input logic [15:0] a, input bit ins, input int gap,
                        input int exp_lat, input string req);
    int          lat;
    logic [31:0] d;
    rd(a, ins, gap, lat, d);
    chk(lat == exp_lat, req, lat, exp_lat);
    chk(d == exp_word(a), "R4 data", d, exp_word(a));
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp", rsp_valid, 0);

    // R3: buffering off, W = 0: same address twice, both go to flash
    rd_chk(16'h080, 1, 2, 1, "R3 first");
    rd_chk(16'h080, 1, 2, 1, "R3 repeat");

    // R2 R5 R6 R7 R8: split 3+1, instr prefetch, W = 3
    cfg_write(32'h0003_0333);
    for (int i = 0; i < NV; i++) begin
      rd_chk(V_ADDR[i], V_INSTR[i], 8, V_LAT[i], "R5/R6/R8 table");
    end

    // R9: trigger 1, miss only, pooled, W = 2
    cfg_write(32'h0002_0013);
    rd_chk(16'h400, 1, 8, 3, "R9 miss");
    rd_chk(16'h410, 1, 8, 0, "R9 prefetched after miss");
    rd_chk(16'h420, 1, 8, 3, "R9 no prefetch after hit");

    // R8: only data prefetch enabled
    cfg_write(32'h0002_0035);
    rd_chk(16'h500, 1, 8, 3, "R8 instr miss");
    rd_chk(16'h510, 1, 8, 3, "R8 instr not prefetched");
    rd_chk(16'h600, 0, 8, 3, "R8 data miss");
    rd_chk(16'h610, 0, 8, 0, "R8 data prefetched");

    // R10 R11: W = 5, instr prefetch on hit or miss
    cfg_write(32'h0005_0033);
    rd_chk(16'h700, 1, 8, 6, "R5 miss W5");
    rd_chk(16'h780, 1, 0, 6, "R10 demand before queued prefetch");
    rd_chk(16'h820, 1, 8, 6, "R5 miss W5 again");
    rd_chk(16'h830, 1, 1, 5, "R11 wait on running prefetch");

    // R12: configuration written while a fetch runs
    cfg_write(32'h0005_0001);
    fork
      rd_chk(16'h900, 1, 0, 6, "R12 fetch keeps old W");
      begin
        repeat (2) @(negedge clk);
        cfg_wdata = 32'h0001_0001;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
      end
    join
    rd_chk(16'h900, 1, 4, 2, "R12 invalidated, new W");

    // R7: pooled LRU, no prefetch, W = 1
    rd_chk(16'hC80, 1, 4, 2, "R7 fill a");
    rd_chk(16'hC90, 1, 4, 2, "R7 fill b");
    rd_chk(16'hCA0, 1, 4, 2, "R7 fill c");
    rd_chk(16'hCB0, 1, 4, 2, "R7 fill d");
    rd_chk(16'hC84, 1, 4, 0, "R7 hit a");
    rd_chk(16'hCC0, 0, 4, 2, "R7 evict b");
    rd_chk(16'hC88, 1, 4, 0, "R7 a kept");
    rd_chk(16'hCA4, 1, 4, 0, "R7 c kept");
    rd_chk(16'hC90, 1, 4, 2, "R7 b gone");
    rd_chk(16'hCC4, 0, 4, 0, "R7 e kept");

    finished = 1'b1;
    report();
    $finish;
  end

endmodule